// File: doc/BRIEF.md
# Bus Clock Mode Controller

This block produces the bus clock of a small controller as a one-cycle enable strobe in the system clock domain. The strobe is derived from one of two tick sources: a fast main oscillator or a slow sub-oscillator. Software selects the source and the ratio by writing mode bits into two control registers. The block decodes those bits into one of seven modes: the main clock divided by 1, 2, 4, 8 or 16; the sub-clock as the bus clock; or the sub-clock as the bus clock with the main oscillator halted.

Any change of source waits until the target oscillator reports that it is stable. The block also handles the entry into stop mode, during which no strobes are produced. When stop is entered from a main-clock mode, the controller falls back to divide-by-8. Bit combinations outside the decode table leave the running mode untouched and raise a sticky flag.

Top module: `busclk_mode_ctrl`

## Requirements
- R1: After reset the mode output is divide-by-8 (code 3), mainRun is 1, illegalFlag is 0, and the register fields hold subSel=0, div8Sel=1, mainHalt=0, subOn=0, divHi=0, divLo=0.
- R2: A write with wrSel=0 updates control register 0, with field bits 7=subSel, 6=div8Sel, 5=mainHalt and 4=subOn. A write with wrSel=1 updates control register 1, with bit 7=divHi and bit 6=divLo. Only bits whose wrMask bit is 1 are written. Register 0 bits 3:0 and register 1 bits 5:0 are ignored.
- R3: When subSel=0 and mainHalt=0, div8Sel=1 decodes to divide-by-8 (code 3). Otherwise {divHi,divLo} decodes as follows: 00 gives divide-by-1 (code 0), 01 gives divide-by-2 (code 1), 10 gives divide-by-4 (code 2), and 11 gives divide-by-16 (code 4).
- R4: When subSel=1 and subOn=1, mainHalt=0 decodes to low-speed (code 5) and mainHalt=1 decodes to low-power (code 6). mainRun is 0 in low-power mode and while stopReq is high, and 1 otherwise.
- R5: Any other field combination leaves the current mode unchanged and sets illegalFlag. illegalFlag stays at 1 until reset.
- R6: Some mode changes wait until the target oscillator is stable. A change from a sub-clock mode into a main-clock mode, or from divide-by-8 into divide-by-1, -2 or -4, waits for mainStable. A change from a main-clock mode into a sub-clock mode waits for subStable.
- R7: In a main-clock mode with divide ratio N, busStrobe is high for one cycle, one cycle after every Nth sampled mainTick.
- R8: In a sub-clock mode, busStrobe is high for one cycle, one cycle after every sampled subTick.
- R9: A mode change restarts the divide count, and a tick sampled in the cycle of the change is not counted. The first strobe under the new mode therefore follows the Nth tick after the change.
- R10: While stopReq is high, busStrobe stays 0 and the mode output does not change. Register writes are still accepted.
- R11: On the first cycle of stopReq, div8Sel is forced to 1 if the current mode is a main-clock mode. If the current mode is a sub-clock mode, div8Sel keeps its value.
- R12: Strobes are produced only while the oscillator of the current source reports stable. While it is unstable, the divide count is held at zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Active-low synchronous reset |
| wrEn | input | 1 | Register write strobe |
| wrSel | input | 1 | 0 selects control register 0, 1 selects control register 1 |
| wrData | input | 8 | Write data |
| wrMask | input | 8 | Per-bit write enable |
| mainTick | input | 1 | One-cycle tick of the main oscillator |
| subTick | input | 1 | One-cycle tick of the sub-oscillator |
| mainStable | input | 1 | Main oscillator stable |
| subStable | input | 1 | Sub-oscillator stable |
| stopReq | input | 1 | Stop mode request, held while stopped |
| busStrobe | output | 1 | Bus clock enable strobe |
| mainRun | output | 1 | Main oscillator run request |
| modeOut | output | 3 | Current decoded mode code |
| illegalFlag | output | 1 | Sticky flag for an illegal register setting |

## Verification
The assertions assume the following about the inputs: the ticks and stability flags are synchronous to clk, reset is low from time zero, and stopReq is a level held for whole cycles. The stimulus drives every input on the falling edge only. Stability flags are mostly high and drop briefly at random, so gated switches both wait and complete. Random writes with random masks reach the illegal field combinations as well as the legal ones, and short stop pulses land in both main-clock and sub-clock modes.

// File: rtl/busclk_pkg.sv
package busclk_pkg;
  localparam int DIV_LOG_W = 3;

  typedef enum logic [2:0] {
    MD_DIV1   = 3'd0,
    MD_DIV2   = 3'd1,
    MD_DIV4   = 3'd2,
    MD_DIV8   = 3'd3,
    MD_DIV16  = 3'd4,
    MD_LOWSPD = 3'd5,
    MD_LOWPWR = 3'd6
  } busMode_e;

  // control to datapath strobes
  typedef struct packed {
    logic                 clrCnt;
    logic                 cntMain;
    logic                 cntSub;
    logic [DIV_LOG_W-1:0] divLog;
  } dpCtl_t;

  function automatic logic isSubMode(busMode_e m);
    return (m == MD_LOWSPD) || (m == MD_LOWPWR);
  endfunction
endpackage

// File: rtl/busclk_ctrl.sv
module busclk_ctrl
  import busclk_pkg::*;
#(
  parameter int REG_W = 8
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             wrEn,
  input  logic             wrSel,
  input  logic [REG_W-1:0] wrData,
  input  logic [REG_W-1:0] wrMask,
  input  logic             mainStable,
  input  logic             subStable,
  input  logic             stopReq,
  output busMode_e         curMode,
  output logic             illegalFlag,
  output logic             mainRun,
  output dpCtl_t           dpCtl
);
  localparam int SUBSEL_B = REG_W - 1;
  localparam int DIV8_B   = REG_W - 2;
  localparam int HALT_B   = REG_W - 3;
  localparam int SUBON_B  = REG_W - 4;
  localparam int DIVHI_B  = REG_W - 1;
  localparam int DIVLO_B  = REG_W - 2;

  logic subSel, div8Sel, mainHalt, subOn, divHi, divLo;
  logic stopPrev, stopEntry;
  logic decValid, needMain, needSub, modeUpd, fromSub, toSub;
  busMode_e decMode;

  always_comb begin
    decValid = 1'b1;
    decMode  = curMode;
    if (!subSel && !mainHalt) begin
      if (div8Sel) decMode = MD_DIV8;
      else begin
        case ({divHi, divLo})
          2'b00:   decMode = MD_DIV1;
          2'b01:   decMode = MD_DIV2;
          2'b10:   decMode = MD_DIV4;
          default: decMode = MD_DIV16;
        endcase
      end
    end else if (subSel && subOn) begin
      decMode = mainHalt ? MD_LOWPWR : MD_LOWSPD;
    end else begin
      decValid = 1'b0;
    end
  end

  always_comb begin
    fromSub   = isSubMode(curMode);
    toSub     = isSubMode(decMode);
    needMain  = (fromSub && !toSub) ||
                (curMode == MD_DIV8 &&
                 (decMode == MD_DIV1 || decMode == MD_DIV2 || decMode == MD_DIV4));
    needSub   = toSub && !fromSub;
    modeUpd   = decValid && (decMode != curMode) && !stopReq &&
                (!needMain || mainStable) && (!needSub || subStable);
    stopEntry = stopReq && !stopPrev;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      subSel      <= 1'b0;
      div8Sel     <= 1'b1;
      mainHalt    <= 1'b0;
      subOn       <= 1'b0;
      divHi       <= 1'b0;
      divLo       <= 1'b0;
      stopPrev    <= 1'b0;
      curMode     <= MD_DIV8;
      illegalFlag <= 1'b0;
    end else begin
      if (wrEn && !wrSel) begin
        if (wrMask[SUBSEL_B]) subSel   <= wrData[SUBSEL_B];
        if (wrMask[DIV8_B])   div8Sel  <= wrData[DIV8_B];
        if (wrMask[HALT_B])   mainHalt <= wrData[HALT_B];
        if (wrMask[SUBON_B])  subOn    <= wrData[SUBON_B];
      end
      if (wrEn && wrSel) begin
        if (wrMask[DIVHI_B]) divHi <= wrData[DIVHI_B];
        if (wrMask[DIVLO_B]) divLo <= wrData[DIVLO_B];
      end
      // stop entry from a main-clock mode falls back to divide-by-8
      if (stopEntry && !fromSub) div8Sel <= 1'b1;
      stopPrev <= stopReq;
      if (!decValid) illegalFlag <= 1'b1;
      if (modeUpd)   curMode     <= decMode;
    end
  end

  always_comb begin
    mainRun        = !stopReq && (curMode != MD_LOWPWR);
    dpCtl.clrCnt   = modeUpd;
    dpCtl.cntMain  = !stopReq && !fromSub && mainStable;
    dpCtl.cntSub   = !stopReq && fromSub && subStable;
    case (curMode)
      MD_DIV2:  dpCtl.divLog = DIV_LOG_W'(1);
      MD_DIV4:  dpCtl.divLog = DIV_LOG_W'(2);
      MD_DIV8:  dpCtl.divLog = DIV_LOG_W'(3);
      MD_DIV16: dpCtl.divLog = DIV_LOG_W'(4);
      default:  dpCtl.divLog = DIV_LOG_W'(0);
    endcase
  end
endmodule

// File: rtl/busclk_div.sv
module busclk_div
  import busclk_pkg::*;
#(
  parameter int MAX_LOG = 4
) (
  input  logic   clk,
  input  logic   rstN,
  input  logic   mainTick,
  input  logic   subTick,
  input  dpCtl_t dpCtl,
  output logic   busStrobe
);
  localparam int CNT_W = MAX_LOG;

  logic [CNT_W-1:0] cnt;
  logic [CNT_W:0]   span;
  logic [CNT_W-1:0] term;

  always_comb begin
    span = ({{CNT_W{1'b0}}, 1'b1} << dpCtl.divLog) - 1'b1;
    term = span[CNT_W-1:0];
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      cnt       <= '0;
      busStrobe <= 1'b0;
    end else if (dpCtl.clrCnt || !(dpCtl.cntMain || dpCtl.cntSub)) begin
      cnt       <= '0;
      busStrobe <= 1'b0;
    end else if (dpCtl.cntSub) begin
      busStrobe <= subTick;
    end else if (mainTick) begin
      if (cnt == term) begin
        cnt       <= '0;
        busStrobe <= 1'b1;
      end else begin
        cnt       <= cnt + 1'b1;
        busStrobe <= 1'b0;
      end
    end else begin
      busStrobe <= 1'b0;
    end
  end
endmodule

// File: rtl/busclk_mode_ctrl.sv
module busclk_mode_ctrl
  import busclk_pkg::*;
#(
  parameter int REG_W   = 8,
  parameter int MAX_LOG = 4
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             wrEn,
  input  logic             wrSel,
  input  logic [REG_W-1:0] wrData,
  input  logic [REG_W-1:0] wrMask,
  input  logic             mainTick,
  input  logic             subTick,
  input  logic             mainStable,
  input  logic             subStable,
  input  logic             stopReq,
  output logic             busStrobe,
  output logic             mainRun,
  output logic [2:0]       modeOut,
  output logic             illegalFlag
);
  busMode_e curMode;
  dpCtl_t   dpCtl;

  busclk_ctrl #(.REG_W(REG_W)) u_ctrl (
    .clk(clk), .rstN(rstN), .wrEn(wrEn), .wrSel(wrSel), .wrData(wrData),
    .wrMask(wrMask), .mainStable(mainStable), .subStable(subStable),
    .stopReq(stopReq), .curMode(curMode), .illegalFlag(illegalFlag),
    .mainRun(mainRun), .dpCtl(dpCtl)
  );

  busclk_div #(.MAX_LOG(MAX_LOG)) u_div (
    .clk(clk), .rstN(rstN), .mainTick(mainTick), .subTick(subTick),
    .dpCtl(dpCtl), .busStrobe(busStrobe)
  );

  assign modeOut = curMode;
endmodule

// File: rtl/busclk_chk.sv
module busclk_chk (
  input logic       clk,
  input logic       rstN,
  input logic       mainTick,
  input logic       subTick,
  input logic       mainStable,
  input logic       subStable,
  input logic       stopReq,
  input logic       busStrobe,
  input logic       mainRun,
  input logic [2:0] modeOut,
  input logic       illegalFlag
);
  a_r1_reset_mode: assert property (@(posedge clk) $rose(rstN) |-> modeOut == 3'd3 && !illegalFlag);

  a_r4_lowpwr_halts: assert property (@(posedge clk) disable iff (!rstN)
    modeOut == 3'd6 |-> !mainRun);

  a_r5_sticky: assert property (@(posedge clk) disable iff (!rstN)
    illegalFlag |=> illegalFlag);

  a_r6_main_gate: assert property (@(posedge clk) disable iff (!rstN)
    (modeOut == 3'd3 && !mainStable) |=> (modeOut != 3'd0 && modeOut != 3'd1 && modeOut != 3'd2));

  a_r6_sub_gate: assert property (@(posedge clk) disable iff (!rstN)
    (modeOut < 3'd5 && !subStable) |=> modeOut < 3'd5);

  a_r8_strobe_source: assert property (@(posedge clk) disable iff (!rstN)
    busStrobe |-> ($past(mainTick) || $past(subTick)));

  a_r10_no_strobe: assert property (@(posedge clk) disable iff (!rstN)
    stopReq |=> !busStrobe);

  a_r10_mode_hold: assert property (@(posedge clk) disable iff (!rstN)
    stopReq |=> $stable(modeOut));
endmodule

bind busclk_mode_ctrl busclk_chk u_chk (.*);

// File: tb/sim_busclk_mode_ctrl.sv
module sim_busclk_mode_ctrl;
  localparam int CLK_P = 10;

  logic clk = 1'b0, rstN = 1'b0;
  logic wrEn = 0, wrSel = 0;
  logic [7:0] wrData = 0, wrMask = 0;
  logic mainTick = 0, subTick = 0, mainStable = 1, subStable = 1, stopReq = 0;
  logic busStrobe, mainRun, illegalFlag;
  logic [2:0] modeOut;

  int total = 0, bad = 0;
  string curTag = "R1";
  bit done = 0;

  // reference state
  bit mSub, mDiv8, mHalt, mOn, mHi, mLo, mStopPrev, mIll, mStb;
  int mMode, mCnt;

  busclk_mode_ctrl u0 (.*);

  always #(CLK_P/2) clk = ~clk;

  function automatic int decodeRef();
    if (!mSub && !mHalt) return mDiv8 ? 3 : (mHi ? (mLo ? 4 : 2) : (mLo ? 1 : 0));
    if (mSub && mOn) return mHalt ? 6 : 5;
    return -1;
  endfunction

  function automatic bit isSub(int m);
    return m == 5 || m == 6;
  endfunction

  function automatic int ratio(int m);
    case (m) 1: return 2; 2: return 4; 3: return 8; 4: return 16; default: return 1; endcase
  endfunction

  task automatic check(string tag, int act, int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", tag, act, exp, $time);
    end
  endtask

  task automatic stepRef();
    int dec; bit upd, needM, needS, enM, enS;
    if (!rstN) begin
      mSub = 0; mDiv8 = 1; mHalt = 0; mOn = 0; mHi = 0; mLo = 0;
      mStopPrev = 0; mIll = 0; mStb = 0; mMode = 3; mCnt = 0;
      return;
    end
    dec   = decodeRef();
    needM = (isSub(mMode) && !isSub(dec)) || (mMode == 3 && (dec == 0 || dec == 1 || dec == 2));
    needS = isSub(dec) && !isSub(mMode);
    upd   = dec >= 0 && dec != mMode && !stopReq && (!needM || mainStable) && (!needS || subStable);
    enM   = !stopReq && !isSub(mMode) && mainStable;
    enS   = !stopReq && isSub(mMode) && subStable;
    if (upd || !(enM || enS)) begin mCnt = 0; mStb = 0; end
    else if (enS) mStb = subTick;
    else if (mainTick) begin
      if (mCnt == ratio(mMode) - 1) begin mCnt = 0; mStb = 1; end
      else begin mCnt++; mStb = 0; end
    end else mStb = 0;
    if (dec < 0) mIll = 1;
    if (wrEn && !wrSel) begin
      if (wrMask[7]) mSub = wrData[7];
      if (wrMask[6]) mDiv8 = wrData[6];
      if (wrMask[5]) mHalt = wrData[5];
      if (wrMask[4]) mOn = wrData[4];
    end
    if (wrEn && wrSel) begin
      if (wrMask[7]) mHi = wrData[7];
      if (wrMask[6]) mLo = wrData[6];
    end
    if (stopReq && !mStopPrev && !isSub(mMode)) mDiv8 = 1;
    mStopPrev = stopReq;
    if (upd) mMode = dec;
  endtask

  always @(posedge clk) begin
    string t;
    stepRef();
    #(CLK_P/4);
    if (rstN && !done) begin
      t = curTag;
      if (curTag == "RND") t = isSub(mMode) ? "R8" : "R7";
      check(t, busStrobe, mStb);
      check(t, modeOut, mMode);
      check(t, mainRun, !stopReq && mMode != 6);
      check(t, illegalFlag, mIll);
    end
  end

  task automatic cyc(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic wr(bit sel, logic [7:0] d, logic [7:0] m);
    @(negedge clk);
    wrEn = 1; wrSel = sel; wrData = d; wrMask = m;
    @(negedge clk);
    wrEn = 0;
  endtask

  task automatic finishRun();
    done = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  endtask

  initial begin
    #(CLK_P * 200000);
    bad++;
    $display("FAIL watchdog expired");
    finishRun();
  end

  initial begin
    int stb;
    void'($urandom(32'd4242));
    cyc(3);
    rstN = 1;
    cyc(2);
    check("R1", modeOut, 3); check("R1", mainRun, 1); check("R1", illegalFlag, 0);

    curTag = "R3";
    mainTick = 1;
    wr(1, 8'h40, 8'hC0); wr(0, 8'h00, 8'h40); cyc(3);
    check("R3", modeOut, 1);
    cyc(12);
    curTag = "R2";
    wr(0, 8'hFF, 8'h0F); wr(1, 8'hFF, 8'h3F); wr(0, 8'hFF, 8'h00); cyc(3);
    check("R2", modeOut, 1); check("R2", illegalFlag, 0);

    curTag = "R6";
    wr(0, 8'h40, 8'h40); cyc(2);
    check("R6", modeOut, 3);
    mainStable = 0;
    wr(1, 8'h80, 8'hC0); wr(0, 8'h00, 8'h40); cyc(4);
    check("R6", modeOut, 3);
    mainStable = 1; cyc(2);
    check("R6", modeOut, 2);
    subStable = 0;
    wr(0, 8'h90, 8'hF0); cyc(4);
    check("R6", modeOut, 2);
    curTag = "R4";
    subStable = 1; cyc(2);
    check("R4", modeOut, 5);
    subTick = 1; cyc(5); subTick = 0;
    wr(0, 8'h20, 8'h20); cyc(2);
    check("R4", modeOut, 6); check("R4", mainRun, 0);

    curTag = "R11";
    wr(0, 8'h00, 8'h20); cyc(2);
    stopReq = 1; cyc(3);
    check("R4", mainRun, 0);
    stopReq = 0; cyc(2);
    wr(0, 8'h00, 8'h80); cyc(2);
    check("R11", modeOut, 2);
    stopReq = 1; cyc(3); stopReq = 0; cyc(2);
    check("R11", modeOut, 3);

    curTag = "R10";
    stb = 0;
    stopReq = 1;
    wr(0, 8'h00, 8'h40);
    for (int i = 0; i < 20; i++) begin cyc(1); stb += busStrobe; end
    check("R10", stb, 0); check("R10", modeOut, 3);
    stopReq = 0; cyc(2);
    check("R10", modeOut, 2);

    curTag = "R9";
    wr(0, 8'h40, 8'h40); cyc(5);
    wr(1, 8'hC0, 8'hC0); wr(0, 8'h00, 8'h40); cyc(40);
    check("R9", modeOut, 4);

    curTag = "R12";
    mainStable = 0; cyc(6); mainStable = 1; cyc(30);

    curTag = "R5";
    wr(0, 8'h80, 8'h90); cyc(3);
    check("R5", modeOut, 4); check("R5", illegalFlag, 1);
    wr(0, 8'h00, 8'h80); cyc(3);
    check("R5", illegalFlag, 1);

    curTag = "RND";
    for (int i = 0; i < 4000; i++) begin
      @(negedge clk);
      mainTick   = ($urandom % 3) == 0;
      subTick    = ($urandom % 11) == 0;
      mainStable = ($urandom % 20) != 0;
      subStable  = ($urandom % 20) != 0;
      if (($urandom % 60) == 0) stopReq = ~stopReq;
      wrEn = ($urandom % 25) == 0;
      wrSel = $urandom % 2; wrData = 8'($urandom); wrMask = 8'($urandom);
    end
    @(negedge clk);
    wrEn = 0; stopReq = 0;
    cyc(4);
    finishRun();
  end
endmodule